// File: doc/BRIEF.md
# Gate Drive Latch Control

This block is the digital decision core of a power-switch gate driver. It takes an on/off command, a fault-latch request and a latch-clear request, all already synchronised to the block clock. It then decides each cycle whether the switch is driven ON or OFF. A sticky fault latch holds the output OFF until a clear arrives while the fault request is low. The clear can never override a live fault request.

Around these priorities the block enforces a minimum ON time and a minimum OFF time, each a 16-bit cycle count. A count is captured at the moment the output changes state and governs only that hold. A fault request cuts an ON hold short and forces the output OFF at once. The OFF hold that follows is timed from that forced turn-off. A command that changes during a hold is acted on in the first cycle after the hold ends, provided it is still present.

Top module: `gate_latch_ctrl`

## Requirements
- R1: With no latch held, no latch request and the hold expired, an asserted command turns `drive_on_o` to 1 at the next clock edge.
- R2: With the hold expired and the command low, an ON output returns to 0 at the next clock edge.
- R3: `latch_req_i` high at an edge sets the latch, and `drive_on_o` is 0 after that edge. This holds whatever the command or a running ON hold.
- R4: While `latch_req_i` is high, `clr_req_i` has no effect: the latch stays held.
- R5: `clr_req_i` high with `latch_req_i` low clears the latch at that edge. The output may turn ON no earlier than the following edge, under the command.
- R6: `latch_n_o` is 0 exactly while the latch is held and 1 otherwise. While it is 0, `drive_on_o` is 0.
- R7: After a turn-off (commanded or forced) with captured OFF count N, the output stays 0 for at least max(N,1) cycles.
- R8: After a turn-on with captured ON count N, the output stays 1 for at least max(N,1) cycles unless a latch request forces it off.
- R9: Each count is sampled on the edge where the output changes state. Later changes of the count inputs do not alter a hold that is already running.
- R10: A count of 0 (or 1) removes the matching constraint, so the output may change on every edge.
- R11: After `rst_ni` the output is 0, the latch is clear, `latch_n_o` is 1, and the OFF hold has already expired.
- R12: A command still asserted (or deasserted) when a hold ends takes effect on the first edge after expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_on_i | input | 1 | Main on/off command, 1 = ON |
| latch_req_i | input | 1 | Fault-latch request, highest priority |
| clr_req_i | input | 1 | Latch-clear request |
| min_on_cyc_i | input | CNT_W | Minimum ON time in cycles, sampled at turn-on |
| min_off_cyc_i | input | CNT_W | Minimum OFF time in cycles, sampled at turn-off |
| drive_on_o | output | 1 | Gate drive state, 1 = ON |
| latch_n_o | output | 1 | Latch status, 0 while held |

## Verification
Two functions can fall in the same cycle, and the bench targets both overlaps. First, a fault request can arrive while an ON hold is still counting. Second, a clear can coincide with a fault request, or a clear and the command can be raised together. A pseudo-random sweep over several small ON/OFF count pairs raises faults, clears and command flips often enough to hit these overlaps many times. Each cycle is judged against an age-since-transition model, which encodes the priority order and the hold lengths directly. A further phase changes the count inputs every cycle to show that only the values captured at a transition matter.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drive_e;
endpackage

// File: rtl/gdl_fault_latch.sv
module gdl_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic held_o
);
  logic held_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= 1'b0;
    else if (set_i)  held_q <= 1'b1;
    else if (clr_i)  held_q <= 1'b0;
  end

  assign held_o = held_q;

  p_latch_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> held_o);
  p_clr_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> held_o);
  p_clr_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && clr_i) |=> !held_o);
endmodule

// File: rtl/gdl_hold_timer.sv
module gdl_hold_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  // last held cycle is the one where cnt==1
  assign expired_o = (cnt_q[CW-1:1] == '0);

  p_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/gdl_drive_fsm.sv
module gdl_drive_fsm
  import gdl_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic          force_off_i,
  input  logic          expired_i,
  input  logic [CW-1:0] min_on_i,
  input  logic [CW-1:0] min_off_i,
  output logic          drive_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  drive_e drive_q, drive_d;

  always_comb begin
    drive_d = drive_q;
    unique case (drive_q)
      DRV_ON:  if (force_off_i || (!cmd_i && expired_i)) drive_d = DRV_OFF;
      DRV_OFF: if (!force_off_i && cmd_i && expired_i)   drive_d = DRV_ON;
      default: drive_d = DRV_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= DRV_OFF;
    else         drive_q <= drive_d;
  end

  assign drive_o    = (drive_q == DRV_ON);
  assign load_o     = (drive_d != drive_q);
  assign load_val_o = (drive_d == DRV_ON) ? min_on_i : min_off_i;

  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_o && !expired_i) |=> !drive_o);
  p_hold_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && !expired_i && !force_off_i) |=> drive_o);
  p_apply_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_i && !force_off_i) |=> (drive_o == $past(cmd_i)));
endmodule

// File: rtl/gate_latch_ctrl.sv
module gate_latch_ctrl #(
  parameter int unsigned CNT_W = gdl_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_on_i,
  input  logic             latch_req_i,
  input  logic             clr_req_i,
  input  logic [CNT_W-1:0] min_on_cyc_i,
  input  logic [CNT_W-1:0] min_off_cyc_i,
  output logic             drive_on_o,
  output logic             latch_n_o
);
  logic             held;
  logic             force_off;
  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;

  gdl_fault_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (latch_req_i),
    .clr_i  (clr_req_i),
    .held_o (held)
  );

  // request acts in the same edge as the latch sets
  assign force_off = latch_req_i | held;

  gdl_hold_timer #(.CW(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  gdl_drive_fsm #(.CW(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_on_i),
    .force_off_i (force_off),
    .expired_i   (expired),
    .min_on_i    (min_on_cyc_i),
    .min_off_i   (min_off_cyc_i),
    .drive_o     (drive_on_o),
    .load_o      (load),
    .load_val_o  (load_val)
  );

  assign latch_n_o = ~held;

  p_force_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_req_i |=> !drive_on_o);
  p_held_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_n_o |-> !drive_on_o);
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_n_o && !latch_req_i && clr_req_i) |=> (!drive_on_o && latch_n_o));
endmodule

// File: tb/sim_gate_latch_ctrl.sv
`timescale 1ns/1ps
module sim_gate_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd = 1'b0, lreq = 1'b0, clr = 1'b0;
  logic [15:0] on_n = '0, off_n = '0;
  logic        drv, latn;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string ctx = "";

  // model state
  bit m_drv, m_lat;
  int m_age, m_lim;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  gate_latch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_on_i(cmd), .latch_req_i(lreq),
    .clr_req_i(clr), .min_on_cyc_i(on_n), .min_off_cyc_i(off_n),
    .drive_on_o(drv), .latch_n_o(latn)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic step();
    string t_drv;
    bit force_off, nd;
    force_off = lreq || m_lat;
    nd = m_drv;
    if (force_off) begin
      nd = 1'b0; t_drv = "R3";
    end else if (cmd != m_drv) begin
      if (m_age >= m_lim) begin nd = cmd; t_drv = cmd ? "R1" : "R2"; end
      else t_drv = m_drv ? "R8" : "R7";
    end else t_drv = cmd ? "R1" : "R2";
    @(posedge clk);
    if (nd != m_drv) begin
      m_lim = at_least1(nd ? int'(on_n) : int'(off_n));
      m_age = 1;
    end else if (m_age < 1000000) m_age++;
    m_drv = nd;
    if (lreq) m_lat = 1'b1; else if (clr) m_lat = 1'b0;
    @(negedge clk);
    chk(ctx != "" ? ctx : t_drv, drv, m_drv);
    chk(ctx != "" ? ctx : "R6", latn, ~m_lat);
  endtask

  task automatic drive_in(input bit c, input bit l, input bit r);
    cmd = c; lreq = l; clr = r;
    step();
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int vals[5] = '{0, 1, 2, 3, 6};
    m_drv = 0; m_lat = 0; m_age = 1000000; m_lim = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", drv, 1'b0);
    chk("R11", latn, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 OFF hold already expired: turns ON at first edge
    ctx = "R11"; off_n = 16'd5; on_n = 16'd0;
    drive_in(1, 0, 0);
    // R10 zero counts: follow every edge
    ctx = "R10"; off_n = 0;
    for (int i = 0; i < 8; i++) drive_in(i[0], 0, 0);
    // R3 fault cuts an ON hold short
    ctx = "R3"; on_n = 16'd6; off_n = 16'd2;
    drive_in(1, 0, 0); drive_in(1, 0, 0);
    drive_in(1, 1, 0);
    // R4 clear blocked by live request
    ctx = "R4";
    for (int i = 0; i < 4; i++) drive_in(1, 1, 1);
    drive_in(1, 0, 0);
    // R5 clear with request low, output follows next edge
    ctx = "R5";
    drive_in(1, 0, 1);
    drive_in(1, 0, 0); drive_in(1, 0, 0);
    // R12 pending command applied on expiry
    ctx = "R12"; on_n = 16'd5; off_n = 16'd4;
    for (int i = 0; i < 12; i++) drive_in(1'b0, 0, 0);
    for (int i = 0; i < 12; i++) drive_in(1'b1, 0, 0);
    // R9 count changes during a hold are ignored
    ctx = "R9"; on_n = 16'd7; off_n = 16'd1;
    drive_in(0, 0, 0); drive_in(0, 0, 0);
    drive_in(1, 0, 0);
    on_n = 16'd0;
    for (int i = 0; i < 9; i++) drive_in(0, 0, 0);
    for (int i = 0; i < 1000; i++) begin
      lfsr = nxt(lfsr);
      on_n = 16'(lfsr[3:0] & 4'h7); off_n = 16'(lfsr[7:4] & 4'h7);
      if (lfsr[9:8] == 2'b00) cmd = ~cmd;
      lreq = (lfsr[13:10] == 4'h0);
      clr = (lfsr[15:14] == 2'b11);
      step();
    end
    // sweep: R1 R2 R3 R7 R8 tagged by cause
    ctx = "";
    foreach (vals[a]) foreach (vals[b]) begin
      on_n = 16'(vals[a]); off_n = 16'(vals[b]);
      for (int i = 0; i < 150; i++) begin
        lfsr = nxt(lfsr);
        if (lfsr[1:0] == 2'b00) cmd = ~cmd;
        lreq = (lfsr[7:4] == 4'h5);
        clr = (lfsr[10:8] == 3'b011);
        step();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule